// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It counts pulses of a receive clock enable, and the bit period is 1, 16 or 64 of those pulses. It detects the start of a frame and, at the higher rates, checks that the start bit is still low at its midpoint. It then samples each data bit at mid-bit, plus an optional parity bit and one stop bit. The finished character goes into a holding register and a ready flag is raised. A host read strobe clears ready.

Parity, overrun and framing faults are kept as sticky flags until the host pulses the error-clear input. A separate break output rises when the line has stayed low through two whole frames in a row. It falls as soon as a high level is sampled. A receive-enable input stops the block from using the line: while it is low, a frame in progress is dropped and no new frame begins. The serial input is assumed to be synchronous to `clk` already. It is read only on cycles where the receive enable pulses. The frame format inputs must stay stable while a frame is being received.

Top module: `rxa_async_rx`

## Requirements
- R1: At rates x16 (`rate_sel`=2'b10) and x64 (`rate_sel`=2'b11), the first enable pulse that sees the line low starts timing. The start bit is checked 8 (x16) or 32 (x64) pulses later. Each later bit is sampled 16 (x16) or 64 (x64) pulses after the one before it.
- R2: At x16 and x64, a low level that has gone high again by the start-bit check is dropped as noise. No character results, and the next real frame is received normally.
- R3: At rate x1 (`rate_sel`=2'b00 or 2'b01), each enable pulse samples one bit. The pulse that first sees the line low is taken as the start bit without validation.
- R4: `len_sel` sets the character length: 2'b00=5, 2'b01=6, 2'b10=7, 2'b11=8 bits. Data arrives least significant bit first. `rx_data` shows the character right-aligned, with the unused high bits zero.
- R5: When `parity_on`=1, one parity bit follows the data. With `parity_even`=1 the count of ones over data and parity must be even; with 0 it must be odd. A mismatch sets `parity_err`.
- R6: `rx_ready` rises one clock after the enable pulse that samples the stop bit. A `rd_strobe` pulse clears it on the next clock. All outputs are zero after reset.
- R7: If a character completes while `rx_ready` is still set and no read is in the same cycle, `overrun_err` is set and `rx_data` takes the newer character.
- R8: A low level sampled at the stop-bit position sets `framing_err`.
- R9: `break_det` rises when two frames in a row complete with every sampled bit low, stop bits included. It falls one clock after an enabled enable pulse samples the line high.
- R10: `parity_err`, `overrun_err` and `framing_err` stay set until an `err_clear` pulse, which clears all three.
- R11: While `rx_enable` is low, the line is ignored and `rx_ready` does not rise. A frame cut short by dropping the enable yields no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per receive clock period |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| rx_enable | input | 1 | Receiver enable |
| rate_sel | input | 2 | Pulses per bit: 0x/01 = 1, 10 = 16, 11 = 64 |
| len_sel | input | 2 | Character length code, 5 to 8 bits |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| rd_strobe | input | 1 | Host read of the character, clears ready |
| err_clear | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Character waiting for the host |
| parity_err | output | 1 | Sticky parity error |
| overrun_err | output | 1 | Sticky overrun error |
| framing_err | output | 1 | Sticky framing error |
| break_det | output | 1 | Line held low across two frames |

## Verification
Data and flag results are registered once. They appear one clock after the enable pulse that samples the stop bit, midway through that bit. Read and error-clear pulses take effect one clock after they are driven. The bench drives the line only in the clock after an enable pulse, keeps each bit for exactly one bit time of pulses, and reads the outputs on falling clock edges only after that settling clock. Mid-bit timing is tested by making each bit correct only for the three pulses around its sampling point. The break test checks the output after one all-low frame (still low) and after two (high).

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;

    localparam int CHAR_MAX = 8;
    localparam int CHAR_MIN = 5;

    typedef enum logic [1:0] {
        RATE_UNIT_A = 2'b00,
        RATE_UNIT   = 2'b01,
        RATE_MID    = 2'b10,
        RATE_BIG    = 2'b11
    } rate_e;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } frame_state_e;

    // One completed frame, handed from the framer to the host registers.
    typedef struct packed {
        logic                valid;
        logic [CHAR_MAX-1:0] data;
        logic                par_bad;
        logic                stop_low;
        logic                all_low;
    } rx_char_t;

    // Bits enter at the top of the shifter; move them down to bit 0.
    function automatic logic [CHAR_MAX-1:0] align_char(
        input logic [CHAR_MAX-1:0] sh,
        input logic [1:0]          len_code
    );
        int unsigned gap;
        gap = CHAR_MAX - CHAR_MIN - int'(len_code);
        return sh >> gap;
    endfunction

endpackage

// File: rtl/rxa_bit_timer.sv
`timescale 1ns/1ps
module rxa_bit_timer
    import rxa_pkg::*;
#(
    parameter int FAC_MID = 16,
    parameter int FAC_BIG = 64,
    localparam int CW = $clog2(FAC_BIG)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] rate,
    input  logic       ld_half,
    input  logic       ld_full,
    output logic       due,
    output logic       unit_rate
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] full_m1;
    logic [CW-1:0] half_m1;

    always_comb begin
        case (rate_e'(rate))
            RATE_MID: begin
                full_m1 = CW'(FAC_MID - 1);
                half_m1 = CW'(FAC_MID / 2 - 1);
            end
            RATE_BIG: begin
                full_m1 = CW'(FAC_BIG - 1);
                half_m1 = CW'(FAC_BIG / 2 - 1);
            end
            default: begin
                full_m1 = '0;
                half_m1 = '0;
            end
        endcase
    end

    assign unit_rate = (rate_e'(rate) == RATE_UNIT) || (rate_e'(rate) == RATE_UNIT_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (ld_half)
                cnt <= half_m1;
            else if (ld_full)
                cnt <= full_m1;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign due = tick && (cnt == '0);

endmodule

// File: rtl/rxa_frame_ctl.sv
`timescale 1ns/1ps
module rxa_frame_ctl
    import rxa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       parity_on,
    input  logic       parity_even,
    input  logic       due,
    input  logic       unit_rate,
    output logic       ld_half,
    output logic       ld_full,
    output rx_char_t   chr
);

    frame_state_e        state, nxt;
    logic [CHAR_MAX-1:0] shreg;
    logic [2:0]          bit_cnt;
    logic                par_acc;
    logic                par_bit;
    logic                seen_high;
    logic                done;
    logic [2:0]          last_idx;

    assign last_idx = 3'd4 + {1'b0, len_sel};

    always_comb begin
        nxt     = state;
        ld_half = 1'b0;
        ld_full = 1'b0;
        done    = 1'b0;
        case (state)
            FR_IDLE: begin
                if (tick && !rxd) begin
                    if (unit_rate) begin
                        nxt     = FR_DATA;
                        ld_full = 1'b1;
                    end else begin
                        nxt     = FR_START;
                        ld_half = 1'b1;
                    end
                end
            end
            FR_START: begin
                if (due) begin
                    if (!rxd) begin
                        nxt     = FR_DATA;
                        ld_full = 1'b1;
                    end else begin
                        nxt = FR_IDLE;
                    end
                end
            end
            FR_DATA: begin
                if (due) begin
                    ld_full = 1'b1;
                    if (bit_cnt == last_idx)
                        nxt = parity_on ? FR_PAR : FR_STOP;
                end
            end
            FR_PAR: begin
                if (due) begin
                    ld_full = 1'b1;
                    nxt     = FR_STOP;
                end
            end
            FR_STOP: begin
                if (due) begin
                    done = 1'b1;
                    nxt  = FR_IDLE;
                end
            end
            default: nxt = FR_IDLE;
        endcase
        if (!en) begin
            nxt  = FR_IDLE;
            done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FR_IDLE;
            shreg     <= '0;
            bit_cnt   <= '0;
            par_acc   <= 1'b0;
            par_bit   <= 1'b0;
            seen_high <= 1'b0;
        end else begin
            state <= nxt;
            if (state == FR_IDLE) begin
                shreg     <= '0;
                bit_cnt   <= '0;
                par_acc   <= 1'b0;
                par_bit   <= 1'b0;
                seen_high <= 1'b0;
            end else if (due && state == FR_DATA) begin
                shreg     <= {rxd, shreg[CHAR_MAX-1:1]};
                bit_cnt   <= bit_cnt + 1'b1;
                par_acc   <= par_acc ^ rxd;
                seen_high <= seen_high | rxd;
            end else if (due && state == FR_PAR) begin
                par_bit   <= rxd;
                seen_high <= seen_high | rxd;
            end
        end
    end

    always_comb begin
        chr.valid    = done;
        chr.data     = align_char(shreg, len_sel);
        chr.par_bad  = parity_on && ((par_acc ^ par_bit) == parity_even);
        chr.stop_low = !rxd;
        chr.all_low  = !seen_high && !rxd;
    end

    // R1: a start bit found high at its midpoint sends the framer back to idle
    assert_start_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (en && state == FR_START && due && rxd) |=> (state == FR_IDLE));

    // R11: with the receiver disabled the framer sits in idle
    assert_disable_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == FR_IDLE));

endmodule

// File: rtl/rxa_host_regs.sv
`timescale 1ns/1ps
module rxa_host_regs
    import rxa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                tick,
    input  logic                rxd,
    input  logic                rd_strobe,
    input  logic                err_clear,
    input  rx_char_t            chr,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                overrun_err,
    output logic                framing_err,
    output logic                break_det
);

    logic zero_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            parity_err  <= 1'b0;
            overrun_err <= 1'b0;
            framing_err <= 1'b0;
            break_det   <= 1'b0;
            zero_prev   <= 1'b0;
        end else begin
            if (err_clear) begin
                parity_err  <= 1'b0;
                overrun_err <= 1'b0;
                framing_err <= 1'b0;
            end
            if (chr.valid) begin
                rx_data  <= chr.data;
                rx_ready <= 1'b1;
                if (rx_ready && !rd_strobe)
                    overrun_err <= 1'b1;
                if (chr.par_bad)
                    parity_err <= 1'b1;
                if (chr.stop_low)
                    framing_err <= 1'b1;
                if (chr.all_low) begin
                    if (zero_prev)
                        break_det <= 1'b1;
                    zero_prev <= 1'b1;
                end else begin
                    zero_prev <= 1'b0;
                end
            end else if (rd_strobe) begin
                rx_ready <= 1'b0;
            end
            if (en && tick && rxd) begin
                break_det <= 1'b0;
                zero_prev <= 1'b0;
            end
        end
    end

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !chr.valid) |=> !rx_ready);

    assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (chr.valid && rx_ready && !rd_strobe) |=> overrun_err);

    assert_framing_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (chr.valid && chr.stop_low) |=> framing_err);

    assert_break_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (en && tick && rxd) |=> !break_det);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun_err && !err_clear) |=> overrun_err);

    assert_parity_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !err_clear) |=> parity_err);

endmodule

// File: rtl/rxa_async_rx.sv
`timescale 1ns/1ps
module rxa_async_rx
    import rxa_pkg::*;
#(
    parameter int FAC_MID = 16,
    parameter int FAC_BIG = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_tick,
    input  logic                rxd,
    input  logic                rx_enable,
    input  logic [1:0]          rate_sel,
    input  logic [1:0]          len_sel,
    input  logic                parity_on,
    input  logic                parity_even,
    input  logic                rd_strobe,
    input  logic                err_clear,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                overrun_err,
    output logic                framing_err,
    output logic                break_det
);

    logic     due;
    logic     unit_rate;
    logic     ld_half;
    logic     ld_full;
    rx_char_t chr;

    rxa_bit_timer #(
        .FAC_MID (FAC_MID),
        .FAC_BIG (FAC_BIG)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (rx_tick),
        .rate      (rate_sel),
        .ld_half   (ld_half),
        .ld_full   (ld_full),
        .due       (due),
        .unit_rate (unit_rate)
    );

    rxa_frame_ctl u_framer (
        .clk         (clk),
        .rst         (rst),
        .en          (rx_enable),
        .tick        (rx_tick),
        .rxd         (rxd),
        .len_sel     (len_sel),
        .parity_on   (parity_on),
        .parity_even (parity_even),
        .due         (due),
        .unit_rate   (unit_rate),
        .ld_half     (ld_half),
        .ld_full     (ld_full),
        .chr         (chr)
    );

    rxa_host_regs u_host (
        .clk         (clk),
        .rst         (rst),
        .en          (rx_enable),
        .tick        (rx_tick),
        .rxd         (rxd),
        .rd_strobe   (rd_strobe),
        .err_clear   (err_clear),
        .chr         (chr),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .parity_err  (parity_err),
        .overrun_err (overrun_err),
        .framing_err (framing_err),
        .break_det   (break_det)
    );

    // R11: ready never rises in the clock after the receiver was disabled
    assert_no_ready_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !$rose(rx_ready));

endmodule

// File: tb/test_rxa_async_rx.sv
`timescale 1ns/1ps
module test_rxa_async_rx;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_tick;
    logic       rxd;
    logic       rx_enable;
    logic [1:0] rate_sel;
    logic [1:0] len_sel;
    logic       parity_on;
    logic       parity_even;
    logic       rd_strobe;
    logic       err_clear;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       parity_err;
    logic       overrun_err;
    logic       framing_err;
    logic       break_det;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rxa_async_rx i_rxa_async_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_tick     (rx_tick),
        .rxd         (rxd),
        .rx_enable   (rx_enable),
        .rate_sel    (rate_sel),
        .len_sel     (len_sel),
        .parity_on   (parity_on),
        .parity_even (parity_even),
        .rd_strobe   (rd_strobe),
        .err_clear   (err_clear),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .parity_err  (parity_err),
        .overrun_err (overrun_err),
        .framing_err (framing_err),
        .break_det   (break_det)
    );

    initial begin
        rx_tick = 1'b0;
        forever begin
            @(negedge clk) rx_tick = 1'b1;
            @(negedge clk) rx_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fac_of(input logic [1:0] r);
        if (r == 2'b10) return 16;
        if (r == 2'b11) return 64;
        return 1;
    endfunction

    task automatic tick_wait(input int n);
        repeat (n) begin
            do @(posedge clk); while (!rx_tick);
        end
    endtask

    task automatic hold(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        tick_wait(n);
    endtask

    task automatic bit_out(input logic b, input bit mid);
        int f;
        f = fac_of(rate_sel);
        if (mid && f > 1) begin
            hold(!b, f / 2 - 1);
            hold(b, 3);
            hold(!b, f / 2 - 2);
        end else begin
            hold(b, f);
        end
    endtask

    task automatic send_char(input logic [7:0] v, input int len, input bit flip_par,
                             input logic stop_v, input bit mid);
        logic p;
        p = 1'b0;
        hold(1'b0, fac_of(rate_sel));
        for (int i = 0; i < len; i++) begin
            bit_out(v[i], mid);
            p = p ^ v[i];
        end
        if (parity_on) begin
            if (!parity_even) p = ~p;
            if (flip_par) p = ~p;
            bit_out(p, mid);
        end
        bit_out(stop_v, mid);
        hold(1'b1, 2 * fac_of(rate_sel));
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] r, input int len, input bit pon, input bit pev);
        @(negedge clk);
        rate_sel    = r;
        len_sel     = 2'(len - 5);
        parity_on   = pon;
        parity_even = pev;
    endtask

    task automatic read_char(input string tag);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk(tag, {31'd0, rx_ready}, 32'd0);
    endtask

    task automatic clear_err();
        @(negedge clk) err_clear = 1'b1;
        @(negedge clk) err_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] vals [4];
        logic [7:0] msk;
        string      tg;
        vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF; vals[3] = 8'h02;

        rst = 1'b1; rxd = 1'b1; rx_enable = 1'b1;
        rate_sel = 2'b10; len_sel = 2'b11; parity_on = 1'b0; parity_even = 1'b0;
        rd_strobe = 1'b0; err_clear = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset ready", {31'd0, rx_ready}, 0);
        chk("R4 reset data", {24'd0, rx_data}, 0);
        chk("R10 reset errors", {29'd0, parity_err, overrun_err, framing_err}, 0);
        chk("R9 reset break", {31'd0, break_det}, 0);

        // R3 (x1) and R4/R5 (x16): sweep length, parity mode and value
        for (int r = 1; r <= 2; r++) begin
            for (int len = 5; len <= 8; len++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    for (int vi = 0; vi < 4; vi++) begin
                        set_cfg(2'(r), len, pm != 0, pm == 2);
                        msk = 8'((9'd1 << len) - 9'd1);
                        tg = (r == 1) ? "R3 data x1" : "R4 data x16";
                        send_char(vals[vi], len, 1'b0, 1'b1, 1'b0);
                        chk("R6 ready after frame", {31'd0, rx_ready}, 1);
                        chk(tg, {24'd0, rx_data}, {24'd0, vals[vi] & msk});
                        chk("R5 no parity error", {31'd0, parity_err}, 0);
                        chk("R8 no framing error", {31'd0, framing_err}, 0);
                        read_char("R6 read clears ready");
                    end
                end
            end
        end

        // R1: bits valid only around the mid-bit sampling point
        set_cfg(2'b10, 8, 1'b1, 1'b1);
        send_char(8'h96, 8, 1'b0, 1'b1, 1'b1);
        chk("R1 mid-bit x16 data", {24'd0, rx_data}, 32'h96);
        chk("R1 mid-bit x16 errors", {29'd0, parity_err, overrun_err, framing_err}, 0);
        read_char("R1 read x16");
        set_cfg(2'b11, 8, 1'b1, 1'b0);
        send_char(8'h69, 8, 1'b0, 1'b1, 1'b1);
        chk("R1 mid-bit x64 data", {24'd0, rx_data}, 32'h69);
        chk("R1 mid-bit x64 errors", {29'd0, parity_err, overrun_err, framing_err}, 0);
        read_char("R1 read x64");

        // R2: short low pulses ignored
        set_cfg(2'b10, 8, 1'b0, 1'b0);
        hold(1'b0, 7);
        hold(1'b1, 40);
        @(negedge clk);
        chk("R2 noise x16 ready", {31'd0, rx_ready}, 0);
        set_cfg(2'b11, 8, 1'b0, 1'b0);
        hold(1'b0, 31);
        hold(1'b1, 100);
        @(negedge clk);
        chk("R2 noise x64 ready", {31'd0, rx_ready}, 0);
        send_char(8'h5A, 8, 1'b0, 1'b1, 1'b0);
        chk("R2 frame after noise", {24'd0, rx_data}, 32'h5A);
        read_char("R2 read");

        // R5 parity error, R10 clear
        set_cfg(2'b10, 7, 1'b1, 1'b0);
        send_char(8'h4B, 7, 1'b1, 1'b1, 1'b0);
        chk("R5 parity error set", {31'd0, parity_err}, 1);
        chk("R5 ready with bad parity", {31'd0, rx_ready}, 1);
        read_char("R5 read");
        clear_err();
        chk("R10 parity cleared", {31'd0, parity_err}, 0);

        // R7 overrun, R10 stickiness
        set_cfg(2'b10, 8, 1'b0, 1'b0);
        send_char(8'h11, 8, 1'b0, 1'b1, 1'b0);
        send_char(8'h22, 8, 1'b0, 1'b1, 1'b0);
        chk("R7 overrun set", {31'd0, overrun_err}, 1);
        chk("R7 newer char kept", {24'd0, rx_data}, 32'h22);
        read_char("R7 read");
        send_char(8'h33, 8, 1'b0, 1'b1, 1'b0);
        chk("R10 overrun sticky", {31'd0, overrun_err}, 1);
        read_char("R10 read");
        clear_err();
        chk("R10 overrun cleared", {31'd0, overrun_err}, 0);

        // R8 framing error
        send_char(8'hC4, 8, 1'b0, 1'b0, 1'b0);
        chk("R8 framing set", {31'd0, framing_err}, 1);
        chk("R8 data kept", {24'd0, rx_data}, 32'hC4);
        read_char("R8 read");
        clear_err();
        chk("R10 framing cleared", {31'd0, framing_err}, 0);

        // R9 break: one all-low frame is not enough, two are
        hold(1'b0, 200);
        @(negedge clk);
        chk("R9 no break after one frame", {31'd0, break_det}, 0);
        tick_wait(140);
        @(negedge clk);
        chk("R9 break after two frames", {31'd0, break_det}, 1);
        chk("R9 break frames framing", {31'd0, framing_err}, 1);
        hold(1'b1, 1);
        @(negedge clk);
        chk("R9 break clears on high", {31'd0, break_det}, 0);
        hold(1'b1, 200);
        read_char("R9 read");
        clear_err();

        // R11 disabled receiver
        @(negedge clk) rx_enable = 1'b0;
        send_char(8'hC3, 8, 1'b0, 1'b1, 1'b0);
        chk("R11 no ready while disabled", {31'd0, rx_ready}, 0);
        @(negedge clk) rx_enable = 1'b1;
        hold(1'b0, 16);
        hold(1'b1, 16);
        hold(1'b0, 16);
        hold(1'b1, 16);
        @(negedge clk) rx_enable = 1'b0;
        hold(1'b1, 128);
        @(negedge clk) rx_enable = 1'b1;
        hold(1'b1, 32);
        @(negedge clk);
        chk("R11 cut frame dropped", {31'd0, rx_ready}, 0);
        send_char(8'h7E, 8, 1'b0, 1'b1, 1'b0);
        chk("R11 frame after enable", {24'd0, rx_data}, 32'h7E);
        chk("R11 ready after enable", {31'd0, rx_ready}, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule